// File: doc/BRIEF.md
# Dual-Channel DMA Control Register Bank

This block is the software-visible register file for a pair of DMA channels that share one address window. Every register kind takes a 16-byte slot in that window. Inside a slot, the copy for channel n sits 4·n bytes above the slot base. Software writes the transfer parameters here: byte count, source, destination, next-descriptor pointer, priority and a control word. The block hands those values to the per-channel movement engines as plain level signals. It also produces two one-cycle command pulses, one to fetch a descriptor and one to abort.

The engines report back through three inputs. Each can raise a completion event, show whether it is busy, and overwrite the current-descriptor register. Completion events are held in a per-channel status bit, and software clears that bit by writing zero to it. The held bits, gated by per-channel mask bits, are merged into one shared interrupt line. Read data is registered and appears one clock after the read strobe.

Top module: `dual_dma_regbank`

## Requirements
- R1: After reset every stored register reads 0, every engine output is 0, `irq` is 0 and `bus_rdata` is 0.
- R2: The slot is `bus_addr[7:4]`: 0 byte count, 1 source, 2 destination, 3 next descriptor, 4 control, 6 priority (low 4 bits kept), 7 current descriptor, 8 interrupt mask, 10 interrupt status. The channel is `bus_addr[3:2]`, and `bus_addr[1:0]` is ignored. Read data appears on `bus_rdata` in the cycle after `bus_rd` and holds until the next read.
- R3: A read of an unused slot (5, 9, 11 to 15) or of channel index 2 or 3 returns 0. Writes to those locations change no register.
- R4: The control word maps as follows: [3:2] source mode, [5:4] destination mode (0 increment, 2 hold), [8:6] burst code, 9 chain, 12 enable, 16 pack, [24:22] sample-size code (0 8-bit, 2 16-bit, 5 32-bit). Each field drives its engine output from the cycle after the write. The other bits read 0, apart from bit 14.
- R5: Control bit 14 reads the channel's `eng_active` input, and writes to bit 14 are ignored.
- R6: Writing 1 to control bit 13 raises `ch_fetch` for exactly one cycle and copies the next-descriptor register into the current-descriptor register. Bit 13 reads 0 after that cycle.
- R7: Writing 1 to control bit 20 raises `ch_abort` for exactly one cycle, and bit 20 then reads 0.
- R8: Clearing the enable bit drops `ch_en` (pause), and setting it again raises `ch_en` (resume). Address, count and descriptor registers are untouched by either.
- R9: The current-descriptor register ignores bus writes. It loads `eng_cdesc` when `eng_cdesc_we` is high.
- R10: An `eng_done` pulse sets status bit 0. A bus write with bit 0 = 0 clears it, and a write with bit 0 = 1 leaves it as it was.
- R11: A completion event in the same cycle as a software clear wins, so the status bit stays 1.
- R12: `irq` is the OR over channels of (status bit 0 AND mask bit 0). The mask is bit 0 of the mask register.
- R13: The two channels are independent: a write, event or command on one changes nothing on the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| eng_done | input | 2 | Per-channel completion event |
| eng_active | input | 2 | Per-channel busy status |
| eng_cdesc_we | input | 2 | Per-channel current-descriptor update strobe |
| eng_cdesc | input | 64 | Per-channel current-descriptor value, channel c at [32c+31:32c] |
| ch_en | output | 2 | Channel enable |
| ch_abort | output | 2 | One-cycle abort command |
| ch_fetch | output | 2 | One-cycle fetch-descriptor command |
| ch_chain | output | 2 | Chain mode |
| ch_pack | output | 2 | Pack mode |
| ch_src_mode | output | 4 | Source address mode, 2 bits per channel |
| ch_dst_mode | output | 4 | Destination address mode, 2 bits per channel |
| ch_burst | output | 6 | Burst code, 3 bits per channel |
| ch_sample | output | 6 | Sample-size code, 3 bits per channel |
| ch_prio | output | 8 | Priority, 4 bits per channel |
| ch_bcnt | output | 64 | Byte count per channel |
| ch_src | output | 64 | Source address per channel |
| ch_dst | output | 64 | Destination address per channel |
| ch_next | output | 64 | Next-descriptor pointer per channel |
| ch_cdesc | output | 64 | Current descriptor per channel |
| irq | output | 1 | Shared interrupt |

## Verification
Every stored bit in this block drives a port directly. A wrong bit therefore shows on an engine output one cycle after the write that caused it, and on `bus_rdata` one cycle after the next read of that slot. A wrong decode of the channel field or the slot field shows up as data turning up in the neighbouring channel or slot, or as a write landing there. A status bit that was set or cleared wrongly shows on `irq` in the cycle after the event, provided its mask bit is set. A command pulse that is held too long or stored shows as `ch_fetch` or `ch_abort` still high a second cycle, or as a 1 in the control readback.

// File: rtl/dma_rb_pkg.sv
package dma_rb_pkg;

  localparam logic [3:0] SL_BCNT  = 4'h0;
  localparam logic [3:0] SL_SRC   = 4'h1;
  localparam logic [3:0] SL_DST   = 4'h2;
  localparam logic [3:0] SL_NEXT  = 4'h3;
  localparam logic [3:0] SL_CTRL  = 4'h4;
  localparam logic [3:0] SL_PRIO  = 4'h6;
  localparam logic [3:0] SL_CDESC = 4'h7;
  localparam logic [3:0] SL_IMASK = 4'h8;
  localparam logic [3:0] SL_ISTAT = 4'hA;

  localparam int unsigned CB_SRC_LO   = 2;
  localparam int unsigned CB_DST_LO   = 4;
  localparam int unsigned CB_BURST_LO = 6;
  localparam int unsigned CB_CHAIN    = 9;
  localparam int unsigned CB_EN       = 12;
  localparam int unsigned CB_FETCH    = 13;
  localparam int unsigned CB_ACT      = 14;
  localparam int unsigned CB_PACK     = 16;
  localparam int unsigned CB_ABORT    = 20;
  localparam int unsigned CB_SAMP_LO  = 22;

  typedef struct packed {
    logic [2:0] sample;
    logic       pack;
    logic       en;
    logic       chain;
    logic [2:0] burst;
    logic [1:0] dst_mode;
    logic [1:0] src_mode;
  } ctrl_t;

  function automatic ctrl_t ctrl_from_word(input logic [31:0] w);
    ctrl_t c;
    c.sample   = w[CB_SAMP_LO +: 3];
    c.pack     = w[CB_PACK];
    c.en       = w[CB_EN];
    c.chain    = w[CB_CHAIN];
    c.burst    = w[CB_BURST_LO +: 3];
    c.dst_mode = w[CB_DST_LO +: 2];
    c.src_mode = w[CB_SRC_LO +: 2];
    return c;
  endfunction

  function automatic logic [31:0] ctrl_to_word(input ctrl_t c);
    logic [31:0] w;
    w = '0;
    w[CB_SAMP_LO +: 3]  = c.sample;
    w[CB_PACK]          = c.pack;
    w[CB_EN]            = c.en;
    w[CB_CHAIN]         = c.chain;
    w[CB_BURST_LO +: 3] = c.burst;
    w[CB_DST_LO +: 2]   = c.dst_mode;
    w[CB_SRC_LO +: 2]   = c.src_mode;
    return w;
  endfunction

endpackage

// File: rtl/dma_rb_rstsync.sv
module dma_rb_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/dma_rb_chan.sv
module dma_rb_chan
  import dma_rb_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned PRIO_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [3:0]        slot_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              done_i,
  input  logic              active_i,
  input  logic              cdesc_we_i,
  input  logic [DW-1:0]     cdesc_i,
  output logic [DW-1:0]     rd_o,
  output logic [DW-1:0]     bcnt_o,
  output logic [DW-1:0]     src_o,
  output logic [DW-1:0]     dst_o,
  output logic [DW-1:0]     next_o,
  output logic [DW-1:0]     cdesc_o,
  output logic [PRIO_W-1:0] prio_o,
  output ctrl_t             ctrl_o,
  output logic              fetch_o,
  output logic              abort_o,
  output logic              stat_o,
  output logic              mask_o
);
  logic [DW-1:0]     bcnt_q, bcnt_d, src_q, src_d, dst_q, dst_d;
  logic [DW-1:0]     next_q, next_d, cdesc_q, cdesc_d;
  logic [PRIO_W-1:0] prio_q, prio_d;
  ctrl_t             ctrl_q, ctrl_d;
  logic              fetch_q, fetch_d, abort_q, abort_d;
  logic              stat_q, stat_d, mask_q, mask_d;
  logic              ctrl_wr, fetch_req;

  assign ctrl_wr   = wr_i && (slot_i == SL_CTRL);
  assign fetch_req = ctrl_wr && wdata_i[CB_FETCH];

  // next-state
  always_comb begin
    bcnt_d  = bcnt_q;
    src_d   = src_q;
    dst_d   = dst_q;
    next_d  = next_q;
    cdesc_d = cdesc_q;
    prio_d  = prio_q;
    ctrl_d  = ctrl_q;
    mask_d  = mask_q;
    stat_d  = stat_q;
    fetch_d = 1'b0;
    abort_d = 1'b0;
    if (cdesc_we_i) cdesc_d = cdesc_i;
    if (wr_i) begin
      case (slot_i)
        SL_BCNT:  bcnt_d = wdata_i;
        SL_SRC:   src_d  = wdata_i;
        SL_DST:   dst_d  = wdata_i;
        SL_NEXT:  next_d = wdata_i;
        SL_CTRL: begin
          ctrl_d  = ctrl_from_word(wdata_i[31:0]);
          fetch_d = wdata_i[CB_FETCH];
          abort_d = wdata_i[CB_ABORT];
        end
        SL_PRIO:  prio_d = wdata_i[PRIO_W-1:0];
        SL_IMASK: mask_d = wdata_i[0];
        SL_ISTAT: if (!wdata_i[0]) stat_d = 1'b0;
        default: ;
      endcase
    end
    if (fetch_req) cdesc_d = next_q;
    if (done_i)    stat_d  = 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt_q  <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      next_q  <= '0;
      cdesc_q <= '0;
      prio_q  <= '0;
      ctrl_q  <= '0;
      mask_q  <= 1'b0;
      stat_q  <= 1'b0;
      fetch_q <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      bcnt_q  <= bcnt_d;
      src_q   <= src_d;
      dst_q   <= dst_d;
      next_q  <= next_d;
      cdesc_q <= cdesc_d;
      prio_q  <= prio_d;
      ctrl_q  <= ctrl_d;
      mask_q  <= mask_d;
      stat_q  <= stat_d;
      fetch_q <= fetch_d;
      abort_q <= abort_d;
    end
  end

  // read mux for this channel
  always_comb begin
    rd_o = '0;
    case (slot_i)
      SL_BCNT:  rd_o = bcnt_q;
      SL_SRC:   rd_o = src_q;
      SL_DST:   rd_o = dst_q;
      SL_NEXT:  rd_o = next_q;
      SL_CTRL: begin
        rd_o[31:0]     = ctrl_to_word(ctrl_q);
        rd_o[CB_ACT]   = active_i;
        rd_o[CB_FETCH] = fetch_q;
        rd_o[CB_ABORT] = abort_q;
      end
      SL_PRIO:  rd_o[PRIO_W-1:0] = prio_q;
      SL_CDESC: rd_o = cdesc_q;
      SL_IMASK: rd_o[0] = mask_q;
      SL_ISTAT: rd_o[0] = stat_q;
      default: ;
    endcase
  end

  assign bcnt_o  = bcnt_q;
  assign src_o   = src_q;
  assign dst_o   = dst_q;
  assign next_o  = next_q;
  assign cdesc_o = cdesc_q;
  assign prio_o  = prio_q;
  assign ctrl_o  = ctrl_q;
  assign fetch_o = fetch_q;
  assign abort_o = abort_q;
  assign stat_o  = stat_q;
  assign mask_o  = mask_q;

  a_r6_fetch_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_q |-> $past(fetch_req));
  a_r6_fetch_loads_cdesc: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |=> (cdesc_q == $past(next_q)));
  a_r7_abort_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q |-> $past(ctrl_wr && wdata_i[CB_ABORT]));
  a_r9_cdesc_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!cdesc_we_i && !fetch_req) |=> $stable(cdesc_q));
  a_r10_clear_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && slot_i == SL_ISTAT && !wdata_i[0] && !done_i) |=> !stat_q);
  a_r11_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> stat_q);
endmodule

// File: rtl/dma_rb_irq.sv
module dma_rb_irq #(
  parameter int unsigned NCHAN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCHAN-1:0] stat_i,
  input  logic [NCHAN-1:0] mask_i,
  output logic             irq_o
);
  logic [NCHAN-1:0] gated;

  for (genvar c = 0; c < NCHAN; c++) begin : g_gate
    assign gated[c] = stat_i[c] & mask_i[c];
  end

  assign irq_o = |gated;

  a_r12_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_i == '0) |-> !irq_o);
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_i == '0) |-> !irq_o);
endmodule

// File: rtl/dual_dma_regbank.sv
module dual_dma_regbank
  import dma_rb_pkg::*;
#(
  parameter int unsigned NCHAN  = 2,
  parameter int unsigned AW     = 8,
  parameter int unsigned DW     = 32,
  parameter int unsigned PRIO_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [AW-1:0]       bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  input  logic [NCHAN-1:0]    eng_done,
  input  logic [NCHAN-1:0]    eng_active,
  input  logic [NCHAN-1:0]    eng_cdesc_we,
  input  logic [NCHAN*DW-1:0] eng_cdesc,
  output logic [NCHAN-1:0]    ch_en,
  output logic [NCHAN-1:0]    ch_abort,
  output logic [NCHAN-1:0]    ch_fetch,
  output logic [NCHAN-1:0]    ch_chain,
  output logic [NCHAN-1:0]    ch_pack,
  output logic [NCHAN*2-1:0]  ch_src_mode,
  output logic [NCHAN*2-1:0]  ch_dst_mode,
  output logic [NCHAN*3-1:0]  ch_burst,
  output logic [NCHAN*3-1:0]  ch_sample,
  output logic [NCHAN*PRIO_W-1:0] ch_prio,
  output logic [NCHAN*DW-1:0] ch_bcnt,
  output logic [NCHAN*DW-1:0] ch_src,
  output logic [NCHAN*DW-1:0] ch_dst,
  output logic [NCHAN*DW-1:0] ch_next,
  output logic [NCHAN*DW-1:0] ch_cdesc,
  output logic                irq
);
  localparam int unsigned CH_LSB   = 2;
  localparam int unsigned CH_W     = 2;
  localparam int unsigned SLOT_LSB = CH_LSB + CH_W;

  logic             rst_s_n;
  logic [CH_W-1:0]  chan_idx;
  logic [3:0]       slot;
  logic             chan_ok;
  logic [DW-1:0]    rd_arr [NCHAN];
  logic [DW-1:0]    rd_mux;
  logic [DW-1:0]    rdata_q, rdata_d;
  logic [NCHAN-1:0] stat_v, mask_v;

  dma_rb_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_o(rst_s_n)
  );

  assign chan_idx = bus_addr[CH_LSB +: CH_W];
  assign slot     = bus_addr[SLOT_LSB +: 4];
  assign chan_ok  = int'(chan_idx) < NCHAN;

  for (genvar c = 0; c < NCHAN; c++) begin : g_ch
    ctrl_t ctl;
    logic  sel;
    assign sel = chan_ok && (chan_idx == CH_W'(c));

    dma_rb_chan #(.DW(DW), .PRIO_W(PRIO_W)) u_chan (
      .clk        (clk),
      .rst_n      (rst_s_n),
      .wr_i       (bus_wr && sel),
      .slot_i     (slot),
      .wdata_i    (bus_wdata),
      .done_i     (eng_done[c]),
      .active_i   (eng_active[c]),
      .cdesc_we_i (eng_cdesc_we[c]),
      .cdesc_i    (eng_cdesc[c*DW +: DW]),
      .rd_o       (rd_arr[c]),
      .bcnt_o     (ch_bcnt[c*DW +: DW]),
      .src_o      (ch_src[c*DW +: DW]),
      .dst_o      (ch_dst[c*DW +: DW]),
      .next_o     (ch_next[c*DW +: DW]),
      .cdesc_o    (ch_cdesc[c*DW +: DW]),
      .prio_o     (ch_prio[c*PRIO_W +: PRIO_W]),
      .ctrl_o     (ctl),
      .fetch_o    (ch_fetch[c]),
      .abort_o    (ch_abort[c]),
      .stat_o     (stat_v[c]),
      .mask_o     (mask_v[c])
    );

    assign ch_en[c]              = ctl.en;
    assign ch_chain[c]           = ctl.chain;
    assign ch_pack[c]            = ctl.pack;
    assign ch_src_mode[c*2 +: 2] = ctl.src_mode;
    assign ch_dst_mode[c*2 +: 2] = ctl.dst_mode;
    assign ch_burst[c*3 +: 3]    = ctl.burst;
    assign ch_sample[c*3 +: 3]   = ctl.sample;
  end

  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NCHAN; c++) begin
      if (chan_ok && (chan_idx == CH_W'(c))) rd_mux = rd_arr[c];
    end
  end

  always_comb rdata_d = bus_rd ? rd_mux : rdata_q;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) rdata_q <= '0;
    else          rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

  dma_rb_irq #(.NCHAN(NCHAN)) u_irq (
    .clk(clk), .rst_n(rst_s_n), .stat_i(stat_v), .mask_i(mask_v), .irq_o(irq)
  );

  a_r3_bad_channel_reads_zero: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_rd && !chan_ok) |=> (bus_rdata == '0));
  a_r2_rdata_holds: assert property (@(posedge clk) disable iff (!rst_s_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/dual_dma_regbank_test.sv
module dual_dma_regbank_test;
  localparam int N  = 2;
  localparam int DW = 32;

  logic clk, rst_n, bus_wr, bus_rd;
  logic [7:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [N-1:0] eng_done, eng_active, eng_cdesc_we;
  logic [N*DW-1:0] eng_cdesc;
  logic [N-1:0] ch_en, ch_abort, ch_fetch, ch_chain, ch_pack;
  logic [N*2-1:0] ch_src_mode, ch_dst_mode;
  logic [N*3-1:0] ch_burst, ch_sample;
  logic [N*4-1:0] ch_prio;
  logic [N*DW-1:0] ch_bcnt, ch_src, ch_dst, ch_next, ch_cdesc;
  logic irq;

  dual_dma_regbank uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_done(eng_done), .eng_active(eng_active), .eng_cdesc_we(eng_cdesc_we),
    .eng_cdesc(eng_cdesc), .ch_en(ch_en), .ch_abort(ch_abort), .ch_fetch(ch_fetch),
    .ch_chain(ch_chain), .ch_pack(ch_pack), .ch_src_mode(ch_src_mode),
    .ch_dst_mode(ch_dst_mode), .ch_burst(ch_burst), .ch_sample(ch_sample),
    .ch_prio(ch_prio), .ch_bcnt(ch_bcnt), .ch_src(ch_src), .ch_dst(ch_dst),
    .ch_next(ch_next), .ch_cdesc(ch_cdesc), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen;

  // control word used throughout: sample 5, pack, enable, chain, burst 3, dst hold
  localparam logic [31:0] CW = (32'd5 << 22) | (32'd1 << 16) | (32'd1 << 12) |
                               (32'd1 << 9) | (32'd3 << 6) | (32'd2 << 4);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data one cycle after each read strobe
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen === 1'b1) begin
      if (exp_q.size() == 0) begin
        chk("unexpected read", bus_rdata, 32'h0);
      end else begin
        chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic bwrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic done_pulse(input int c);
    @(negedge clk);
    eng_done[c] = 1'b1;
    @(negedge clk);
    eng_done[c] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    eng_done = '0; eng_active = '0; eng_cdesc_we = '0; eng_cdesc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 ch_en", {30'b0, ch_en}, 32'h0);
    chk("R1 rdata", bus_rdata, 32'h0);
    chk("R1 ch_bcnt0", ch_bcnt[31:0], 32'h0);
    bread(8'h40, 32'h0, "R1 ctrl0");
    bread(8'hA4, 32'h0, "R1 istat1");

    // R2 / R13 map and interleave
    bwrite(8'h00, 32'h0000_0100);
    bwrite(8'h04, 32'h0000_0200);
    bwrite(8'h10, 32'h8000_0000);
    bwrite(8'h14, 32'h9000_0000);
    bwrite(8'h20, 32'hA000_0010);
    bwrite(8'h34, 32'h0000_7000);
    bwrite(8'h64, 32'hFFFF_FFFF);
    bread(8'h00, 32'h0000_0100, "R2 bcnt0");
    bread(8'h04, 32'h0000_0200, "R13 bcnt1");
    bread(8'h03, 32'h0000_0100, "R2 low addr bits ignored");
    bread(8'h14, 32'h9000_0000, "R2 src1");
    bread(8'h24, 32'h0, "R13 dst1 untouched");
    bread(8'h64, 32'h0000_000F, "R2 prio1 width");
    bread(8'h60, 32'h0, "R13 prio0 untouched");
    chk("R2 ch_src0 port", ch_src[31:0], 32'h8000_0000);
    chk("R2 ch_next1 port", ch_next[63:32], 32'h0000_7000);
    chk("R2 ch_prio port", {24'b0, ch_prio}, 32'h0000_00F0);

    // R3 unmapped
    bwrite(8'h50, 32'hDEAD_BEEF);
    bwrite(8'h08, 32'h1234_5678);
    bread(8'h50, 32'h0, "R3 slot5");
    bread(8'h08, 32'h0, "R3 channel2");
    bread(8'hF0, 32'h0, "R3 slot15");
    bread(8'h00, 32'h0000_0100, "R3 ch0 unchanged");
    bread(8'h04, 32'h0000_0200, "R3 ch1 unchanged");

    // R4 control fields
    bwrite(8'h40, 32'hFFFF_FFFF & ~(32'd1 << 13) & ~(32'd1 << 20));
    bread(8'h40, 32'h01C1_13FC, "R4 only defined bits stored");
    bwrite(8'h40, CW);
    chk("R4 en", {30'b0, ch_en}, 32'h1);
    chk("R4 burst", {29'b0, ch_burst[2:0]}, 32'd3);
    chk("R4 sample", {29'b0, ch_sample[2:0]}, 32'd5);
    chk("R4 dst mode", {30'b0, ch_dst_mode[1:0]}, 32'd2);
    chk("R4 src mode", {30'b0, ch_src_mode[1:0]}, 32'd0);
    chk("R4 chain/pack", {30'b0, ch_chain[0], ch_pack[0]}, 32'h3);
    chk("R13 ch1 ctrl idle", {26'b0, ch_burst[5:3], ch_sample[5:3]}, 32'h0);
    bread(8'h40, CW, "R4 ctrl readback");

    // R5 active status
    @(negedge clk); eng_active[0] = 1'b1;
    bread(8'h40, CW | (32'd1 << 14), "R5 active reads 1");
    @(negedge clk); eng_active[0] = 1'b0;
    bwrite(8'h40, CW | (32'd1 << 14));
    bread(8'h40, CW, "R5 write to active ignored");

    // R6 fetch
    bwrite(8'h30, 32'h0000_3000);
    bwrite(8'h40, CW | (32'd1 << 13));
    chk("R6 fetch pulse", {30'b0, ch_fetch}, 32'h1);
    chk("R6 cdesc port", ch_cdesc[31:0], 32'h0000_3000);
    @(negedge clk);
    chk("R6 fetch one cycle", {30'b0, ch_fetch}, 32'h0);
    bread(8'h70, 32'h0000_3000, "R6 cdesc loaded");
    bread(8'h40, CW, "R6 fetch bit reads 0");
    bread(8'h74, 32'h0, "R13 ch1 cdesc untouched");

    // R7 abort
    bwrite(8'h40, CW | (32'd1 << 20));
    chk("R7 abort pulse", {30'b0, ch_abort}, 32'h1);
    @(negedge clk);
    chk("R7 abort one cycle", {30'b0, ch_abort}, 32'h0);
    bread(8'h40, CW, "R7 abort bit reads 0");

    // R8 pause / resume
    bwrite(8'h40, CW & ~(32'd1 << 12));
    chk("R8 paused", {30'b0, ch_en}, 32'h0);
    bread(8'h70, 32'h0000_3000, "R8 cdesc kept on pause");
    bread(8'h10, 32'h8000_0000, "R8 src kept on pause");
    bwrite(8'h40, CW);
    chk("R8 resumed", {30'b0, ch_en}, 32'h1);
    bread(8'h00, 32'h0000_0100, "R8 bcnt kept on resume");

    // R9 current descriptor
    bwrite(8'h70, 32'h0000_1234);
    bread(8'h70, 32'h0000_3000, "R9 bus write ignored");
    @(negedge clk);
    eng_cdesc[63:32] = 32'h0000_5550; eng_cdesc_we[1] = 1'b1;
    @(negedge clk);
    eng_cdesc_we[1] = 1'b0;
    bread(8'h74, 32'h0000_5550, "R9 engine update");
    bread(8'h70, 32'h0000_3000, "R13 ch0 cdesc untouched");

    // R10 / R12 status and mask
    done_pulse(0);
    chk("R12 masked irq low", {31'b0, irq}, 32'h0);
    bread(8'hA0, 32'h1, "R10 status set");
    bwrite(8'h80, 32'h1);
    chk("R12 irq high", {31'b0, irq}, 32'h1);
    bwrite(8'hA0, 32'h1);
    bread(8'hA0, 32'h1, "R10 write 1 no effect");
    bwrite(8'hA0, 32'h0);
    chk("R12 irq low after clear", {31'b0, irq}, 32'h0);
    bread(8'hA0, 32'h0, "R10 write 0 clears");

    // R11 event beats clear
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'hA0; bus_wdata = 32'h0; eng_done[0] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; eng_done[0] = 1'b0;
    chk("R11 irq stays", {31'b0, irq}, 32'h1);
    bread(8'hA0, 32'h1, "R11 status stays set");
    bwrite(8'hA0, 32'h0);

    // R13 channel 1 events
    bwrite(8'h84, 32'h1);
    done_pulse(1);
    chk("R13 ch1 irq", {31'b0, irq}, 32'h1);
    bread(8'hA0, 32'h0, "R13 ch0 status untouched");
    bread(8'hA4, 32'h1, "R13 ch1 status");
    bwrite(8'h80, 32'h0);
    chk("R12 ch1 still drives irq", {31'b0, irq}, 32'h1);
    bwrite(8'h84, 32'h0);
    chk("R12 all masked", {31'b0, irq}, 32'h0);

    repeat (3) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 32'h0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule